// File: doc/BRIEF.md
# Microwire Serial EEPROM Master

This block lets on-chip logic read and program a three-wire serial EEPROM that has 16-bit words. A host places one request at a time on a simple strobe interface. The request carries an operation code, a word address and, for writes, a data word. The controller then builds the serial frame and drives chip select, the serial clock and the data line into the device. It samples the device's data output, and it finishes the request with a one-cycle done pulse. After a read, the word appears on `rd_data`.

The serial clock comes from the system clock. Its low and high phases last `LO_CYC` and `HI_CYC` system cycles, so the defaults at a 100 MHz system clock give 250 ns low and 750 ns high. The `addr8` input selects the device's address width, either 6 or 8 bits. The write-enable and write-disable frames grow or shrink with that width. After a write, the controller waits for the device's internal programming to finish. It does this by polling the data line from the device, and the poll is bounded by `POLL_LIMIT` serial clocks. To move a block of words, the host repeats single-word requests.

Top module: `uwire_eeprom_master`

## Requirements
- R1: A read (`req_op` = 0) drives chip select high for one serial period with the data line low. It then sends 1,1,0 and the word address MSB first, using 8 bits when `addr8`=1 and otherwise the low 6 bits. After that it gives 17 more serial clocks, samples the device at the end of each high phase, drops the first sample and presents the last 16 samples, MSB first, on `rd_data`.
- R2: A write (`req_op` = 1) sends the select period, then 1,0,1, then the address as in R1, then `req_wdata` MSB first. Chip select then falls, so the window carries 1+3+6+16 = 26 or 1+3+8+16 = 28 rising clocks.
- R3: Write-enable (`req_op` = 2) and write-disable (`req_op` = 3) send the select period and then 1,0,0. Next come 1,1 for enable or 0,0 for disable, and zeros fill the frame to a length of 9 bits (`addr8`=0) or 11 bits (`addr8`=1).
- R4: After the last write data bit, chip select stays low for one serial period and then rises again. The serial clock then runs until a sample of the device data line reads 1.
- R5: When `POLL_LIMIT` poll clocks pass without a 1, `timeout` goes high and the request still completes. `timeout` holds its value until the next accepted request clears it.
- R6: Chip select goes low for one full serial period before every done pulse. The serial clock stays low whenever chip select is low, and chip select stays low while the block is idle.
- R7: `busy` rises in the cycle after a request is accepted. `done` is a single-cycle pulse, issued in the first cycle in which `busy` is low again.
- R8: The block ignores `req_valid` while `busy` is high.
- R9: Each serial clock high phase lasts exactly `HI_CYC` system cycles. The data line to the device changes only while the serial clock is low.
- R10: While reset is held, and just after it, chip select, serial clock, data out, `busy`, `done`, `timeout` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 read, 1 write, 2 write-enable, 3 write-disable |
| req_addr | input | 8 | Word address (low 6 bits used when `addr8`=0) |
| req_wdata | input | 16 | Word to program |
| addr8 | input | 1 | 1 selects an 8-bit device address, 0 a 6-bit one |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read |
| timeout | output | 1 | Last write poll ran out of clocks |
| ee_cs | output | 1 | Chip select to the device |
| ee_sk | output | 1 | Serial clock to the device |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
The assertions assume that `ee_do` changes only after a rising serial clock and holds steady until the end of the high phase. They also assume that `addr8` holds steady for the whole request. The bench keeps to both. Its device model updates its output one system cycle after it sees a rising serial clock, and `HI_CYC` is above one. The bench changes `addr8` and the request fields only on the falling system clock edge while the block is idle.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_MX = 8;
    localparam int PFX_W   = 3;
    localparam int FRAME_W = PFX_W + ADDR_MX + DATA_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_WREN  = 2'd2,
        OP_WRDIS = 2'd3
    } uw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_SHIFT,
        ST_RDATA,
        ST_WGAP,
        ST_WPOLL,
        ST_TAIL
    } uw_state_e;

endpackage

// File: rtl/uwire_sk_timer.sv
module uwire_sk_timer #(
    parameter int LO_CYC = 25,
    parameter int HI_CYC = 75
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sk_phase,
    output logic bit_end
);
    localparam int PERIOD = LO_CYC + HI_CYC;
    localparam int CW     = $clog2(PERIOD);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          last;

    assign last     = (cnt_q == CW'(PERIOD - 1));
    assign sk_phase = (cnt_q >= CW'(LO_CYC));
    assign bit_end  = run && last;

    always_comb begin
        if (!run || last) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uwire_frame_build.sv
module uwire_frame_build
    import uwire_pkg::*;
(
    input  uw_op_e                op,
    input  logic [ADDR_MX-1:0]    addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  addr8,
    output logic [FRAME_W-1:0]    frame,
    output logic [LEN_W-1:0]      flen
);
    localparam int SHORT_AW = 6;
    localparam int PAD      = ADDR_MX - SHORT_AW;

    logic [PFX_W-1:0]   pfx;
    logic [ADDR_MX-1:0] afield;

    always_comb begin
        unique case (op)
            OP_READ:  begin pfx = 3'b110; afield = addr; end
            OP_WRITE: begin pfx = 3'b101; afield = addr; end
            OP_WREN:  begin pfx = 3'b100; afield = addr8 ? 8'hC0 : 8'h30; end
            default:  begin pfx = 3'b100; afield = '0; end
        endcase
        if (addr8) frame = {pfx, afield, wdata};
        else       frame = {pfx, afield[SHORT_AW-1:0], wdata, {PAD{1'b0}}};
        flen = LEN_W'(PFX_W + (addr8 ? ADDR_MX : SHORT_AW))
             + ((op == OP_WRITE) ? LEN_W'(DATA_W) : '0);
    end
endmodule

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master
    import uwire_pkg::*;
#(
    parameter int LO_CYC     = 25,
    parameter int HI_CYC     = 75,
    parameter int POLL_LIMIT = 100000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [7:0]  req_addr,
    input  logic [15:0] req_wdata,
    input  logic        addr8,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        timeout,
    output logic        ee_cs,
    output logic        ee_sk,
    output logic        ee_di,
    input  logic        ee_do
);
    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam int RD_BITS = DATA_W + 1;

    typedef struct packed {
        uw_state_e          st;
        logic [LEN_W-1:0]   bits;
        logic [LEN_W-1:0]   flen;
        logic [FRAME_W-1:0] frame;
        uw_op_e             op;
        logic [DATA_W-1:0]  rsh;
        logic [DATA_W-1:0]  rdata;
        logic [PW-1:0]      poll;
        logic               done;
        logic               tmo;
    } regs_t;

    regs_t r_d, r_q;

    logic [FRAME_W-1:0] bld_frame;
    logic [LEN_W-1:0]   bld_len;
    logic               sk_phase, bit_end, cs_on;

    uwire_frame_build u_build (
        .op    (uw_op_e'(req_op)),
        .addr  (req_addr),
        .wdata (req_wdata),
        .addr8 (addr8),
        .frame (bld_frame),
        .flen  (bld_len)
    );

    uwire_sk_timer #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (r_q.st != ST_IDLE),
        .sk_phase (sk_phase),
        .bit_end  (bit_end)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: if (req_valid) begin
                r_d.st    = ST_SEL;
                r_d.frame = bld_frame;
                r_d.flen  = bld_len;
                r_d.op    = uw_op_e'(req_op);
                r_d.bits  = '0;
                r_d.tmo   = 1'b0;
            end
            ST_SEL: if (bit_end) r_d.st = ST_SHIFT;
            ST_SHIFT: if (bit_end) begin
                r_d.frame = r_q.frame << 1;
                if (r_q.bits == r_q.flen - 1'b1) begin
                    r_d.bits = '0;
                    if (r_q.op == OP_READ)       r_d.st = ST_RDATA;
                    else if (r_q.op == OP_WRITE) r_d.st = ST_WGAP;
                    else                         r_d.st = ST_TAIL;
                end else begin
                    r_d.bits = r_q.bits + 1'b1;
                end
            end
            ST_RDATA: if (bit_end) begin
                r_d.rsh = {r_q.rsh[DATA_W-2:0], ee_do};
                if (r_q.bits == LEN_W'(RD_BITS - 1)) begin
                    r_d.rdata = {r_q.rsh[DATA_W-2:0], ee_do};
                    r_d.bits  = '0;
                    r_d.st    = ST_TAIL;
                end else begin
                    r_d.bits = r_q.bits + 1'b1;
                end
            end
            ST_WGAP: if (bit_end) begin
                r_d.st   = ST_WPOLL;
                r_d.poll = '0;
            end
            ST_WPOLL: if (bit_end) begin
                if (ee_do) begin
                    r_d.st = ST_TAIL;
                end else if (r_q.poll == PW'(POLL_LIMIT - 1)) begin
                    r_d.tmo = 1'b1;
                    r_d.st  = ST_TAIL;
                end else begin
                    r_d.poll = r_q.poll + 1'b1;
                end
            end
            default: if (bit_end) begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.op    <= OP_READ;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_on   = (r_q.st == ST_SEL) || (r_q.st == ST_SHIFT) ||
                     (r_q.st == ST_RDATA) || (r_q.st == ST_WPOLL);
    assign ee_cs   = cs_on;
    assign ee_sk   = sk_phase && cs_on;
    assign ee_di   = (r_q.st == ST_SHIFT) && r_q.frame[FRAME_W-1];
    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign rd_data = r_q.rdata;
    assign timeout = r_q.tmo;
endmodule

// File: rtl/uwire_eeprom_master_chk.sv
module uwire_eeprom_master_chk #(
    parameter int HI_CYC = 75
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di
);
    localparam int HW = $clog2(HI_CYC + 2);
    logic [HW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (!rst_n)     hi_run <= '0;
        else if (ee_sk) hi_run <= hi_run + 1'b1;
        else            hi_run <= '0;
    end

    a_r6_sk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ee_cs);
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    a_r9_di_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
    a_r9_hi_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_sk) |-> (hi_run == HW'(HI_CYC)));
endmodule

bind uwire_eeprom_master uwire_eeprom_master_chk #(.HI_CYC(HI_CYC)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .ee_cs (ee_cs),
    .ee_sk (ee_sk),
    .ee_di (ee_di)
);

// File: tb/uwire_eeprom_master_bench.sv
module uwire_eeprom_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LO = 2;
    localparam int HI = 3;
    localparam int PLIM = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_addr = 8'd0;
    logic [15:0] req_wdata = 16'd0;
    logic        addr8 = 1'b0;
    logic        busy, done, timeout, ee_cs, ee_sk, ee_di;
    logic [15:0] rd_data;
    logic        ee_do;

    int n_chk = 0;
    int n_bad = 0;
    int busy_cfg = 5;

    always #(CLK_PERIOD/2) clk = ~clk;

    uwire_eeprom_master #(.LO_CYC(LO), .HI_CYC(HI), .POLL_LIMIT(PLIM)) u_uwire_eeprom_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .addr8(addr8),
        .busy(busy), .done(done), .rd_data(rd_data), .timeout(timeout),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    // ---------------- serial EEPROM model ----------------
    localparam int M_WAIT = 0, M_CMD = 1, M_READ = 2, M_WDATA = 3, M_POLL = 4, M_IGN = 5;
    logic [15:0] mem [256];
    int          mode, cnt, rcnt, wcnt, busyleft, hcnt, last_hi;
    int          win_edges, last_edges, prev_edges;
    logic [31:0] win_bits, last_bits;
    logic [9:0]  cmd, nc;
    logic [15:0] rword, wsh, nw;
    logic [7:0]  waddr, ma;
    logic [1:0]  mop, top2;
    logic        wen, pend, cs_p, sk_p;

    always @(posedge clk) begin
        cs_p <= ee_cs;
        sk_p <= ee_sk;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= {i[7:0], i[7:0]} ^ 16'h5A3C;
            mode <= M_WAIT; wen <= 1'b0; pend <= 1'b0; ee_do <= 1'b0;
            cnt <= 0; rcnt <= 0; wcnt <= 0; busyleft <= 0; hcnt <= 0; last_hi <= 0;
            win_edges <= 0; last_edges <= 0; prev_edges <= 0;
            win_bits <= '0; last_bits <= '0; cmd <= '0; rword <= '0; wsh <= '0; waddr <= '0;
        end else begin
            if (ee_sk) hcnt <= hcnt + 1;
            else begin
                if (sk_p) last_hi <= hcnt;
                hcnt <= 0;
            end
            if (ee_cs && !cs_p) begin
                win_edges <= 0; win_bits <= '0; ee_do <= 1'b0;
                mode <= pend ? M_POLL : M_WAIT; cnt <= 0; cmd <= '0;
            end else if (!ee_cs && cs_p) begin
                prev_edges <= last_edges; last_edges <= win_edges; last_bits <= win_bits;
                if (mode == M_POLL) pend <= 1'b0;
            end else if (ee_cs && ee_sk && !sk_p) begin
                win_edges <= win_edges + 1;
                win_bits  <= {win_bits[30:0], ee_di};
                case (mode)
                    M_WAIT: if (ee_di) begin mode <= M_CMD; cnt <= 0; cmd <= '0; end
                    M_CMD: begin
                        nc = {cmd[8:0], ee_di};
                        cmd <= nc;
                        cnt <= cnt + 1;
                        if (cnt == (addr8 ? 9 : 7)) begin
                            mop  = addr8 ? nc[9:8] : nc[7:6];
                            ma   = addr8 ? nc[7:0] : {2'b00, nc[5:0]};
                            top2 = addr8 ? nc[7:6] : nc[5:4];
                            if (mop == 2'b10) begin mode <= M_READ; rcnt <= 0; rword <= mem[ma]; end
                            else if (mop == 2'b01) begin mode <= M_WDATA; wcnt <= 0; waddr <= ma; end
                            else begin
                                if (mop == 2'b00 && top2 == 2'b11) wen <= 1'b1;
                                if (mop == 2'b00 && top2 == 2'b00) wen <= 1'b0;
                                mode <= M_IGN;
                            end
                        end
                    end
                    M_READ: begin
                        ee_do <= (rcnt == 0) ? 1'b0 : rword[16 - rcnt];
                        rcnt  <= rcnt + 1;
                    end
                    M_WDATA: begin
                        nw = {wsh[14:0], ee_di};
                        wsh <= nw;
                        wcnt <= wcnt + 1;
                        if (wcnt == 15) begin
                            if (wen) begin mem[waddr] <= nw; busyleft <= busy_cfg; end
                            else busyleft <= 0;
                            pend <= 1'b1;
                            mode <= M_IGN;
                        end
                    end
                    M_POLL: begin
                        if (busyleft != 0) begin busyleft <= busyleft - 1; ee_do <= 1'b0; end
                        else ee_do <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic l, input logic [7:0] a,
                         input logic [15:0] wd);
        int waited;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; addr8 = l;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 busy after accept", {31'd0, busy}, 32'd1);
        waited = 0;
        while (done !== 1'b1 && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        chk("R7 done reached (watchdog)", {31'd0, done}, 32'd1);
        chk("R7 busy low at done", {31'd0, busy}, 32'd0);
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic        l;
        logic [7:0]  a;
        logic [15:0] wd;
        logic [15:0] rd;
        logic [5:0]  el;
        logic [5:0]  ep;
        logic [11:0] bits;
        logic        cb;
    } vec_t;

    localparam vec_t VEC [13] = '{
        '{2'd0, 1'b1, 8'h12, 16'h0000, 16'h482E, 6'd29, 6'd0,  12'h000, 1'b0},
        '{2'd0, 1'b0, 8'h05, 16'h0000, 16'h5F39, 6'd27, 6'd0,  12'h000, 1'b0},
        '{2'd1, 1'b1, 8'h12, 16'hBEEF, 16'h0000, 6'd1,  6'd28, 12'h000, 1'b0},
        '{2'd0, 1'b1, 8'h12, 16'h0000, 16'h482E, 6'd29, 6'd0,  12'h000, 1'b0},
        '{2'd2, 1'b1, 8'h00, 16'h0000, 16'h0000, 6'd12, 6'd0,  12'h4C0, 1'b1},
        '{2'd1, 1'b1, 8'h12, 16'hBEEF, 16'h0000, 6'd6,  6'd28, 12'h000, 1'b0},
        '{2'd0, 1'b1, 8'h12, 16'h0000, 16'hBEEF, 6'd29, 6'd0,  12'h000, 1'b0},
        '{2'd1, 1'b0, 8'h3F, 16'h8001, 16'h0000, 6'd6,  6'd26, 12'h000, 1'b0},
        '{2'd0, 1'b0, 8'h3F, 16'h0000, 16'h8001, 6'd27, 6'd0,  12'h000, 1'b0},
        '{2'd3, 1'b0, 8'h00, 16'h0000, 16'h0000, 6'd10, 6'd0,  12'h100, 1'b1},
        '{2'd1, 1'b0, 8'h3F, 16'h1234, 16'h0000, 6'd1,  6'd26, 12'h000, 1'b0},
        '{2'd0, 1'b0, 8'h3F, 16'h0000, 16'h8001, 6'd27, 6'd0,  12'h000, 1'b0},
        '{2'd0, 1'b1, 8'hFF, 16'h0000, 16'hA5C3, 6'd29, 6'd0,  12'h000, 1'b0}
    };

    initial begin
        repeat (PLIM * 4000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: state during and after reset
        chk("R10 cs in reset", {31'd0, ee_cs}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 sk", {31'd0, ee_sk}, 32'd0);
        chk("R10 di", {31'd0, ee_di}, 32'd0);
        chk("R10 busy", {31'd0, busy}, 32'd0);
        chk("R10 done", {31'd0, done}, 32'd0);
        chk("R10 timeout", {31'd0, timeout}, 32'd0);
        chk("R10 rd_data", {16'd0, rd_data}, 32'd0);

        // table walk: R1 reads, R2 write frames, R3 enable/disable frames, R4 poll window
        for (int k = 0; k < 13; k++) begin
            issue(VEC[k].op, VEC[k].l, VEC[k].a, VEC[k].wd);
            if (VEC[k].op == 2'd0) chk("R1 read word", {16'd0, rd_data}, {16'd0, VEC[k].rd});
            chk(VEC[k].op == 2'd1 ? "R4 poll window clocks" :
                (VEC[k].op == 2'd0 ? "R1 read frame clocks" : "R3 frame clocks"),
                last_edges, {26'd0, VEC[k].el});
            if (VEC[k].ep != 0) chk("R2 write frame clocks", prev_edges, {26'd0, VEC[k].ep});
            if (VEC[k].cb) chk("R3 frame bits", {20'd0, last_bits[11:0]}, {20'd0, VEC[k].bits});
            chk("R5 no timeout", {31'd0, timeout}, 32'd0);
        end

        // R9: high phase length seen by the device
        chk("R9 high phase length", last_hi, HI);

        // R8: a second strobe while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_addr = 8'h12; addr8 = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_addr = 8'h00;
        @(negedge clk);
        req_valid = 1'b0;
        while (done !== 1'b1) @(negedge clk);
        chk("R8 read unaffected", {16'd0, rd_data}, 32'h0000BEEF);
        chk("R8 single frame clocks", last_edges, 29);
        begin
            int extra = 0;
            repeat (400) begin
                @(negedge clk);
                if (done === 1'b1 || ee_cs === 1'b1) extra++;
            end
            chk("R8 no extra command", extra, 0);
        end

        // R5: poll limit, sticky flag, cleared by next request
        issue(2'd2, 1'b1, 8'h00, 16'h0000);
        busy_cfg = 1000;
        issue(2'd1, 1'b1, 8'h20, 16'h1111);
        chk("R5 timeout raised", {31'd0, timeout}, 32'd1);
        chk("R5 poll clocks at limit", last_edges, PLIM);
        chk("R6 cs low after request", {31'd0, ee_cs}, 32'd0);
        repeat (20) @(negedge clk);
        chk("R5 timeout holds", {31'd0, timeout}, 32'd1);
        busy_cfg = 5;
        issue(2'd0, 1'b1, 8'h20, 16'h0000);
        chk("R5 timeout cleared", {31'd0, timeout}, 32'd0);
        chk("R2 word stored", {16'd0, rd_data}, 32'h00001111);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule